// File: doc/BRIEF.md
# Duplicated Mailbox Channel with Acknowledgment Watchdog

This block carries one 32-bit message at a time from a sender to a receiver, as a single-slot mailbox channel hardened for safety use. When the sender posts a word, the block writes it into two separate storage copies in the same cycle. With each copy it also stores a CRC-8 check code of the word. While the message is offered, the block checks that both copies agree and that each copy still matches its own check code. If any part of this check fails, the message is withheld, a sticky data-fault flag is raised, and the channel locks.

Once a message is posted, a watchdog counts the cycles until the receiver acknowledges it. When the count reaches a threshold set at an input port, the stored message is offered again, and the count starts over. After a fixed number of retries, the next expiry raises a sticky timeout-fault flag and locks the channel until reset. A two-bit fault-injection input lets a test damage one stored copy on purpose, to exercise the integrity check.

Top module: `dup_mbox_chan`

## Requirements
- R1: After reset, `snd_ready` is 1 and `rcv_valid`, `fault_data` and `fault_timeout` are all 0.
- R2: A post takes place on a clock edge where `snd_valid` and `snd_ready` are both high. In the next cycle, `rcv_valid` is high and `rcv_data` equals the posted word. The word stays stable until the receiver takes it with `rcv_ready`.
- R3: `snd_ready` is low from the post until the receiver acknowledges the message. A `snd_valid` during that time posts nothing.
- R4: When `rcv_valid` and `rcv_ready` are both high, the message is taken and `rcv_valid` falls. A `rcv_ack` pulse after that returns the channel to idle, and `snd_ready` is high in the next cycle.
- R5: When `fi_ctl[0]` is high during a post, data bit 0 of the second copy is inverted. The copies then disagree, so `rcv_valid` stays low, and `fault_data` is 1 one cycle after the post cycle.
- R6: Each copy carries a CRC-8 of the word (polynomial 0x07, initial value 0x00, message bits taken MSB first). When `fi_ctl[1]` is high during a post, bit 0 of the first copy's stored code is inverted. The message is then withheld, and `fault_data` is raised exactly as in R5.
- R7: While a message is outstanding, a counter starts at 0 on the post and advances once per cycle. If no acknowledgment arrives first, the message is offered again `tmo_limit` cycles after the receiver took it in the first cycle after the post. The retried message carries the same data.
- R8: On each retry the counter restarts from zero. An acknowledgment after a retry completes the transfer normally, with no fault.
- R9: After 2 retries (MAX_RETRY), the next expiry sets `fault_timeout`. From then on, `rcv_valid` stays 0 and `snd_ready` stays 0.
- R10: Both fault flags are sticky. Only `rst` clears them.
- R11: A `rcv_ack` that arrives while the message is still offered and not yet taken has no effect: `rcv_valid` stays high and `snd_ready` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| snd_valid | input | 1 | Sender offers a word |
| snd_data | input | 32 | Word to post |
| snd_ready | output | 1 | Channel can accept a post |
| fi_ctl | input | 2 | Fault injection at post: bit 0 damages copy-2 data, bit 1 damages copy-1 code |
| rcv_valid | output | 1 | Verified message on offer |
| rcv_data | output | 32 | Offered message |
| rcv_ready | input | 1 | Receiver takes the offered message |
| rcv_ack | input | 1 | Receiver acknowledges a taken message |
| tmo_limit | input | 8 | Acknowledgment timeout threshold in cycles |
| fault_data | output | 1 | Sticky copy-mismatch or check-code fault |
| fault_timeout | output | 1 | Sticky retries-exhausted fault |

## Verification
The bench builds the block with its defaults: a 32-bit word, an 8-bit timeout counter and MAX_RETRY of 2. It drives `tmo_limit` to 6. This short window lets the bench count the exact spacing of each re-offer in cycles. It also lets it walk the whole retry sequence to the timeout fault within a few dozen cycles. Each of the two injection bits is exercised on its own, so the copy comparison and the check-code test are each shown to block delivery.

// File: rtl/dmb_pkg.sv
package dmb_pkg;

    localparam int unsigned MSG_W = 32;
    localparam int unsigned CRC_W = 8;
    localparam logic [CRC_W-1:0] CRC_POLY = 8'h07;
    localparam logic [CRC_W-1:0] CRC_INIT = 8'h00;

    typedef enum logic [1:0] {
        CH_IDLE    = 2'd0,
        CH_OFFER   = 2'd1,
        CH_WAITACK = 2'd2,
        CH_LOCKED  = 2'd3
    } ch_state_e;

    typedef struct packed {
        logic [MSG_W-1:0] word;
        logic [CRC_W-1:0] code;
    } copy_t;

    function automatic logic [CRC_W-1:0] crc8_calc(input logic [MSG_W-1:0] d);
        logic [CRC_W-1:0] c;
        logic fb;
        c = CRC_INIT;
        for (int i = MSG_W - 1; i >= 0; i--) begin
            fb = c[CRC_W-1] ^ d[i];
            c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
        end
        return c;
    endfunction

endpackage

// File: rtl/dmb_copy.sv
module dmb_copy
    import dmb_pkg::*;
#(
    parameter bit DAMAGE_WORD = 1'b0,
    parameter bit DAMAGE_CODE = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [MSG_W-1:0] din,
    input  logic             fi_en,
    output logic [MSG_W-1:0] dout,
    output logic             code_ok
);

    localparam logic [MSG_W-1:0] WORD_FLIP = MSG_W'(DAMAGE_WORD);
    localparam logic [CRC_W-1:0] CODE_FLIP = CRC_W'(DAMAGE_CODE);

    copy_t slot;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot.word <= '0;
            slot.code <= crc8_calc('0);
        end else if (wr) begin
            slot.word <= din ^ (fi_en ? WORD_FLIP : '0);
            slot.code <= crc8_calc(din) ^ (fi_en ? CODE_FLIP : '0);
        end
    end

    assign dout    = slot.word;
    assign code_ok = (crc8_calc(slot.word) == slot.code);

endmodule

// File: rtl/dmb_watchdog.sv
module dmb_watchdog #(
    parameter int unsigned CNT_W     = 8,
    parameter int unsigned MAX_RETRY = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             busy,
    input  logic             done,
    input  logic [CNT_W-1:0] limit,
    output logic             retry,
    output logic             exhausted
);

    localparam int unsigned RC_W = $clog2(MAX_RETRY + 1) + 1;
    localparam logic [RC_W-1:0] RC_MAX = RC_W'(MAX_RETRY);

    logic [CNT_W-1:0] cnt;
    logic [RC_W-1:0]  rcnt;
    logic             expire;

    assign expire    = busy && !done && (cnt >= limit);
    assign retry     = expire && (rcnt < RC_MAX);
    assign exhausted = expire && (rcnt >= RC_MAX);

    always_ff @(posedge clk) begin
        if (rst || start) begin
            cnt  <= '0;
            rcnt <= '0;
        end else if (retry) begin
            cnt  <= '0;
            rcnt <= rcnt + 1'b1;
        end else if (busy && cnt != '1) begin
            cnt <= cnt + 1'b1;
        end
    end

    assert_retry_bound_R9: assert property (@(posedge clk) disable iff (rst)
        rcnt <= RC_MAX);

    assert_restart_on_retry_R8: assert property (@(posedge clk) disable iff (rst)
        retry |=> (cnt == '0));

endmodule

// File: rtl/dup_mbox_chan.sv
module dup_mbox_chan
    import dmb_pkg::*;
#(
    parameter int unsigned CNT_W     = 8,
    parameter int unsigned MAX_RETRY = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             snd_valid,
    input  logic [MSG_W-1:0] snd_data,
    output logic             snd_ready,
    input  logic [1:0]       fi_ctl,
    output logic             rcv_valid,
    output logic [MSG_W-1:0] rcv_data,
    input  logic             rcv_ready,
    input  logic             rcv_ack,
    input  logic [CNT_W-1:0] tmo_limit,
    output logic             fault_data,
    output logic             fault_timeout
);

    localparam int unsigned NCOPY = 2;

    ch_state_e        st, st_nx;
    logic             post, intact, busy, acked;
    logic             wd_retry, wd_exh;
    logic [MSG_W-1:0] cp_word [NCOPY];
    logic [NCOPY-1:0] cp_ok;
    logic             set_fd, set_ft;

    assign post = snd_valid && snd_ready;

    for (genvar g = 0; g < NCOPY; g++) begin : g_copy
        dmb_copy #(
            .DAMAGE_WORD(g == 1),
            .DAMAGE_CODE(g == 0)
        ) u_copy (
            .clk    (clk),
            .rst    (rst),
            .wr     (post),
            .din    (snd_data),
            .fi_en  (fi_ctl[g == 0 ? 1 : 0]),
            .dout   (cp_word[g]),
            .code_ok(cp_ok[g])
        );
    end

    assign intact = (cp_word[0] == cp_word[1]) && (&cp_ok);
    assign busy   = (st == CH_OFFER) || (st == CH_WAITACK);
    assign acked  = (st == CH_WAITACK) && rcv_ack;

    dmb_watchdog #(
        .CNT_W    (CNT_W),
        .MAX_RETRY(MAX_RETRY)
    ) u_wd (
        .clk      (clk),
        .rst      (rst),
        .start    (post),
        .busy     (busy),
        .done     (acked),
        .limit    (tmo_limit),
        .retry    (wd_retry),
        .exhausted(wd_exh)
    );

    always_comb begin
        st_nx  = st;
        set_fd = 1'b0;
        set_ft = 1'b0;
        unique case (st)
            CH_IDLE: if (snd_valid) st_nx = CH_OFFER;
            CH_OFFER: begin
                if (!intact) begin
                    st_nx  = CH_LOCKED;
                    set_fd = 1'b1;
                end else if (wd_exh) begin
                    st_nx  = CH_LOCKED;
                    set_ft = 1'b1;
                end else if (wd_retry) begin
                    st_nx = CH_OFFER;
                end else if (rcv_ready) begin
                    st_nx = CH_WAITACK;
                end
            end
            CH_WAITACK: begin
                if (rcv_ack) begin
                    st_nx = CH_IDLE;
                end else if (wd_exh) begin
                    st_nx  = CH_LOCKED;
                    set_ft = 1'b1;
                end else if (wd_retry) begin
                    st_nx = CH_OFFER;
                end
            end
            default: st_nx = CH_LOCKED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st            <= CH_IDLE;
            fault_data    <= 1'b0;
            fault_timeout <= 1'b0;
        end else begin
            st <= st_nx;
            if (set_fd) fault_data    <= 1'b1;
            if (set_ft) fault_timeout <= 1'b1;
        end
    end

    assign snd_ready = (st == CH_IDLE);
    assign rcv_valid = (st == CH_OFFER) && intact;
    assign rcv_data  = cp_word[0];

    assert_hold_sender_R3: assert property (@(posedge clk) disable iff (rst)
        post |=> !snd_ready);

    assert_offer_verified_R5: assert property (@(posedge clk) disable iff (rst)
        rcv_valid |-> (cp_word[0] == cp_word[1]) && cp_ok[0] && cp_ok[1]);

    assert_offer_stable_R2: assert property (@(posedge clk) disable iff (rst)
        (rcv_valid && !rcv_ready && !wd_retry && !wd_exh) |=> $stable(rcv_data) && rcv_valid);

    assert_sticky_data_R10: assert property (@(posedge clk) disable iff (rst)
        fault_data |=> fault_data);

    assert_sticky_tmo_R10: assert property (@(posedge clk) disable iff (rst)
        fault_timeout |=> fault_timeout);

    assert_locked_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (fault_data || fault_timeout) |-> (!rcv_valid && !snd_ready));

endmodule

// File: tb/sim_dup_mbox_chan.sv
`timescale 1ns/1ps
module sim_dup_mbox_chan;

    localparam int LIM = 6;

    logic        clk = 1'b0;
    logic        rst;
    logic        snd_valid;
    logic [31:0] snd_data;
    logic        snd_ready;
    logic [1:0]  fi_ctl;
    logic        rcv_valid;
    logic [31:0] rcv_data;
    logic        rcv_ready;
    logic        rcv_ack;
    logic [7:0]  tmo_limit;
    logic        fault_data;
    logic        fault_timeout;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    dup_mbox_chan u0 (
        .clk(clk), .rst(rst), .snd_valid(snd_valid), .snd_data(snd_data),
        .snd_ready(snd_ready), .fi_ctl(fi_ctl), .rcv_valid(rcv_valid),
        .rcv_data(rcv_data), .rcv_ready(rcv_ready), .rcv_ack(rcv_ack),
        .tmo_limit(tmo_limit), .fault_data(fault_data), .fault_timeout(fault_timeout)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; snd_valid = 1'b0; snd_data = '0; fi_ctl = 2'b00;
        rcv_ready = 1'b0; rcv_ack = 1'b0; tmo_limit = 8'(LIM);
        step(); step();
        rst = 1'b0;
    endtask

    task automatic post(input logic [31:0] d, input logic [1:0] fi);
        snd_valid = 1'b1; snd_data = d; fi_ctl = fi;
        step();
        snd_valid = 1'b0; fi_ctl = 2'b00;
    endtask

    task automatic take();
        rcv_ready = 1'b1;
        step();
        rcv_ready = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk(snd_ready == 1'b1, "R1 snd_ready", 64'(snd_ready), 1);
        chk(rcv_valid == 1'b0, "R1 rcv_valid", 64'(rcv_valid), 0);
        chk({fault_data, fault_timeout} == 2'b00, "R1 faults", 64'({fault_data, fault_timeout}), 0);
    endtask

    task automatic t_basic(input logic [31:0] d);
        do_reset();
        post(d, 2'b00);
        chk(rcv_valid == 1'b1, "R2 offer", 64'(rcv_valid), 1);
        chk(rcv_data == d, "R2 data", 64'(rcv_data), 64'(d));
        chk(snd_ready == 1'b0, "R3 hold", 64'(snd_ready), 0);
        snd_valid = 1'b1; snd_data = ~d;
        step(); step();
        snd_valid = 1'b0;
        chk(rcv_data == d && rcv_valid, "R2/R3 stable", 64'(rcv_data), 64'(d));
        take();
        chk(rcv_valid == 1'b0, "R4 taken", 64'(rcv_valid), 0);
        chk(snd_ready == 1'b0, "R3 until ack", 64'(snd_ready), 0);
        rcv_ack = 1'b1;
        step();
        rcv_ack = 1'b0;
        chk(snd_ready == 1'b1, "R4 idle", 64'(snd_ready), 1);
        chk(rcv_valid == 1'b0, "R4 no offer", 64'(rcv_valid), 0);
    endtask

    task automatic t_ack_early();
        do_reset();
        post(32'h0BAD_F00D, 2'b00);
        rcv_ack = 1'b1;
        step();
        rcv_ack = 1'b0;
        chk(rcv_valid == 1'b1, "R11 still offered", 64'(rcv_valid), 1);
        chk(snd_ready == 1'b0, "R11 still held", 64'(snd_ready), 0);
        take();
        rcv_ack = 1'b1;
        step();
        rcv_ack = 1'b0;
        chk(snd_ready == 1'b1, "R11 normal finish", 64'(snd_ready), 1);
    endtask

    task automatic t_inject(input logic [1:0] fi, input string req);
        do_reset();
        post(32'h1234_5678, fi);
        chk(rcv_valid == 1'b0, req, 64'(rcv_valid), 0);
        step();
        chk(fault_data == 1'b1, req, 64'(fault_data), 1);
        chk(snd_ready == 1'b0 && rcv_valid == 1'b0, req, 64'({snd_ready, rcv_valid}), 0);
        snd_valid = 1'b1; rcv_ready = 1'b1;
        repeat (10) step();
        snd_valid = 1'b0; rcv_ready = 1'b0;
        chk(fault_data && !snd_ready && !rcv_valid, "R10 data sticky", 64'({fault_data, snd_ready, rcv_valid}), 3'b100);
        do_reset();
        chk(fault_data == 1'b0 && snd_ready, "R10 rst clears", 64'({fault_data, snd_ready}), 2'b01);
    endtask

    task automatic t_retry_ack();
        int gap;
        do_reset();
        post(32'hCAFE_0001, 2'b00);
        take();
        gap = 0;
        while (!rcv_valid && gap < 50) begin step(); gap++; end
        chk(gap == LIM, "R7 retry spacing", 64'(gap), 64'(LIM));
        chk(rcv_data == 32'hCAFE_0001, "R7 retry data", 64'(rcv_data), 64'h CAFE_0001);
        take();
        gap = 0;
        while (!rcv_valid && gap < 50) begin step(); gap++; end
        chk(gap == LIM, "R8 restart spacing", 64'(gap), 64'(LIM));
        take();
        rcv_ack = 1'b1;
        step();
        rcv_ack = 1'b0;
        chk(snd_ready && !fault_timeout, "R8 ack after retry", 64'({snd_ready, fault_timeout}), 2'b10);
    endtask

    task automatic t_timeout();
        int offers, gap;
        do_reset();
        post(32'h5555_AAAA, 2'b00);
        offers = 1;
        take();
        gap = 0;
        while (!fault_timeout && gap < 200) begin
            if (rcv_valid) begin offers++; take(); end
            else step();
            gap++;
        end
        chk(offers == 3, "R9 retries", 64'(offers), 3);
        chk(fault_timeout == 1'b1, "R9 fault", 64'(fault_timeout), 1);
        snd_valid = 1'b1;
        repeat (20) step();
        snd_valid = 1'b0;
        chk(!snd_ready && !rcv_valid && fault_timeout, "R10 tmo sticky", 64'({snd_ready, rcv_valid, fault_timeout}), 3'b001);
        do_reset();
        chk(!fault_timeout && snd_ready, "R10 tmo cleared", 64'({fault_timeout, snd_ready}), 2'b01);
    endtask

    initial begin
        rst = 1'b1;
        t_reset();
        t_basic(32'hDEAD_BEEF);
        t_basic(32'h0000_0001);
        t_ack_early();
        t_inject(2'b01, "R5 mismatch");
        t_inject(2'b10, "R6 crc");
        t_retry_ack();
        t_timeout();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule